// File: doc/BRIEF.md
# Cascadable Priority Interrupt Controller

This block collects eight interrupt request lines, decides which one should be served next, and signals a processor through a single interrupt output. Every request line is synchronized and then captured on a rising edge or by its level, chosen per line. Among captured, unmasked requests the lowest-numbered line wins. A request is held off while a line of the same or higher priority is still being served.

The processor answers with two acknowledge pulses. At the end of the first pulse the winning line leaves the pending set and is marked as in service. During the second pulse the block drives a vector byte. The upper five bits of that byte come from a programmed base and the lower three bits are the line number. An end-of-interrupt command removes the in-service mark.

Several controllers can be chained. A master whose winning line is flagged as carrying a subordinate puts that line number on a 3-bit cascade bus and does not drive the vector. A subordinate drives the vector only when the cascade value equals its programmed identity. The data bus has separate input, output and output-enable signals. All bus strobes are sampled on the block clock.

Top module: `pic_cascade`

## Requirements
- R1: In edge mode (trigger bit 0, the reset value) a line becomes pending only on a 0-to-1 change of its synchronized input. If the input is still high after its acknowledge, no new request is made. If the input falls before the acknowledge, the pending bit is lost.
- R2: In level mode (trigger bit 1) a high synchronized input is pending. After the acknowledge and the end-of-interrupt, an input that is still high is pending again.
- R3: A mask bit of 1 keeps its line from raising `intr`, but the line still shows as pending in the request read. The mask resets to 8'hFF.
- R4: Line 0 has the highest priority. An acknowledge always takes the lowest-numbered request that is pending, unmasked and not blocked.
- R5: `intr` is high only when some line is pending, unmasked, and numbered below every in-service line. A pending line is blocked by an in-service line of equal or higher priority.
- R6: Acknowledge takes two low pulses on `inta_n` and works whatever the state of `cs_n`. When the first pulse ends, the winner's pending bit is cleared and its in-service bit is set. While the second pulse is low, `dout_oe`=1 and `dout`={base[4:0], line[2:0]}.
- R7: If no line is eligible when the first pulse ends, the vector carries line 7 and the in-service register does not change.
- R8: A command write (addr=0) with bits 7:6=00 is an end-of-interrupt. With bit 5=0 it clears the highest-priority in-service bit. With bit 5=1 it clears the bit numbered by bits 2:0. It can fall in the same cycle as the end of a first pulse, and then both effects apply.
- R9: Register access needs `cs_n`=0. A write happens once per low phase of `wr_n`, and a write with `cs_n`=1 has no effect. A command write with bits 7:6=01 selects the target of data writes (addr=1) through bits 2:0: 0 mask, 1 trigger mode, 2 subordinate map, 3 base (written from bits 7:3), 4 identity (bits 2:0), 5 in-service (read only). A read at addr=0 returns the pending requests. A read at addr=1 returns the selected register, with the base in bits 7:3.
- R10: On a master (`is_master`=1), when the winning line has its subordinate-map bit set, `cas_out` carries that line number and `cas_oe`=1 from the first pulse until the end of the second. In that case the master does not drive the vector. Otherwise `cas_oe` stays 0.
- R11: A subordinate (`is_master`=0) acts only if `cas_in` equals its identity when the first pulse ends. Without a match it neither sets an in-service bit nor drives `dout_oe`.

Top module ports are listed below.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cs_n | input | 1 | Chip select, active low |
| rd_n | input | 1 | Read strobe, active low |
| wr_n | input | 1 | Write strobe, active low |
| addr | input | 1 | Selects command or data register |
| din | input | 8 | Write data |
| dout | output | 8 | Read data or vector |
| dout_oe | output | 1 | High while `dout` should be driven |
| irq | input | 8 | Asynchronous request lines |
| intr | output | 1 | Interrupt to the processor |
| inta_n | input | 1 | Acknowledge pulses, active low |
| is_master | input | 1 | 1 = master, 0 = subordinate |
| cas_in | input | 3 | Cascade value seen by a subordinate |
| cas_out | output | 3 | Cascade value driven by a master |
| cas_oe | output | 1 | High while `cas_out` is valid |

## Verification
Two functions can land on the same clock edge. The end of the first acknowledge pulse sets an in-service bit, and an end-of-interrupt write clears one. The bench provokes this by releasing `inta_n` and pulsing a command write on the same clock edge while line 3 is in service and line 1 is pending. The in-service read-back must then show only line 1, and the vector must name line 1. The same register thus shows both the cleared old bit and the newly set bit. This proves that neither update was lost.

// File: rtl/pic_pkg.sv
// Shared constants for the priority interrupt controller.
package pic_pkg;
    localparam int NUM_IRQ  = 8;
    localparam int LVL_W    = $clog2(NUM_IRQ);
    localparam int DATA_W   = 8;
    localparam int BASE_W   = DATA_W - LVL_W;
    localparam int SYNC_STG = 2;

    // Command opcodes in bits 7:6 of an addr=0 write.
    localparam logic [1:0] OP_EOI = 2'b00;
    localparam logic [1:0] OP_SEL = 2'b01;

    // Targets of addr=1 accesses.
    localparam logic [2:0] SEL_MASK   = 3'd0;
    localparam logic [2:0] SEL_TRIG   = 3'd1;
    localparam logic [2:0] SEL_SLAVES = 3'd2;
    localparam logic [2:0] SEL_BASE   = 3'd3;
    localparam logic [2:0] SEL_IDENT  = 3'd4;
    localparam logic [2:0] SEL_INSVC  = 3'd5;

    typedef enum logic [1:0] {
        ACK_IDLE,
        ACK_FIRST,
        ACK_GAP,
        ACK_SECOND
    } ack_state_e;
endpackage

// File: rtl/pic_req_capture.sv
// Request capture: synchronizes the asynchronous lines and keeps the
// pending register. Assumes irq_async may change at any time; ack_clr is
// one-hot and arrives in the cycle the acknowledge commits.
module pic_req_capture #(
    parameter int N      = pic_pkg::NUM_IRQ,
    parameter int STAGES = pic_pkg::SYNC_STG
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] irq_async,
    input  logic [N-1:0] level_mode,
    input  logic [N-1:0] ack_clr,
    output logic [N-1:0] irr
);
    logic [STAGES-1:0][N-1:0] sync_q;
    logic [N-1:0]             irq_s;
    logic [N-1:0]             irq_d;
    logic [N-1:0]             irr_next;

    assign irq_s = sync_q[STAGES-1];

    // Synchronizer chain, previous-sample copy and pending register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sync_q <= '0;
            irq_d  <= '0;
            irr    <= '0;
        end else begin
            sync_q[0] <= irq_async;
            for (int s = 1; s < STAGES; s++) begin
                sync_q[s] <= sync_q[s-1];
            end
            irq_d <= irq_s;
            irr   <= irr_next;
        end
    end

    genvar g;
    generate
        for (g = 0; g < N; g++) begin : g_line
            logic set_req;
            // Per-line set condition by trigger mode; a low input drops the bit.
            always_comb begin
                set_req     = level_mode[g] ? irq_s[g] : (irq_s[g] & ~irq_d[g]);
                irr_next[g] = irq_s[g] & ~ack_clr[g] & (irr[g] | set_req);
            end

            a_r1_low_drops: assert property (@(posedge clk) disable iff (!rst_n)
                !irq_s[g] |=> !irr[g]);
        end
    endgenerate
endmodule

// File: rtl/pic_priority.sv
// Fixed-priority resolver: line 0 wins. A line is eligible when pending,
// unmasked, and no in-service bit at its own or a higher priority is set.
module pic_priority #(
    parameter int N     = pic_pkg::NUM_IRQ,
    parameter int LVL_W = pic_pkg::LVL_W
) (
    input  logic [N-1:0]     irr,
    input  logic [N-1:0]     mask,
    input  logic [N-1:0]     isr,
    output logic             win_valid,
    output logic [LVL_W-1:0] win_lvl
);
    logic [N-1:0] isr_prefix;
    logic [N-1:0] eligible;

    genvar g;
    generate
        for (g = 0; g < N; g++) begin : g_prefix
            if (g == 0) begin : g_first
                assign isr_prefix[g] = isr[g];
            end else begin : g_rest
                assign isr_prefix[g] = isr_prefix[g-1] | isr[g];
            end
        end
    endgenerate

    assign eligible = irr & ~mask & ~isr_prefix;

    // Pick the lowest-numbered eligible line.
    always_comb begin
        win_valid = |eligible;
        win_lvl   = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (eligible[i]) win_lvl = LVL_W'(i);
        end
    end
endmodule

// File: rtl/pic_ack_seq.sv
// Acknowledge sequencer: follows the two inta_n pulses, commits the winner
// at the end of the first, drives cascade lines on a master and gates the
// vector during the second. Assumes inta_n is synchronous to clk.
module pic_ack_seq #(
    parameter int N     = pic_pkg::NUM_IRQ,
    parameter int LVL_W = pic_pkg::LVL_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             inta_n,
    input  logic             is_master,
    input  logic             win_valid,
    input  logic [LVL_W-1:0] win_lvl,
    input  logic [N-1:0]     slave_map,
    input  logic [LVL_W-1:0] cas_in,
    input  logic [LVL_W-1:0] ident,
    output logic [N-1:0]     commit_set,
    output logic             vec_drive,
    output logic [LVL_W-1:0] ack_lvl,
    output logic [LVL_W-1:0] cas_out,
    output logic             cas_oe
);
    import pic_pkg::*;

    ack_state_e       state_q;
    logic [LVL_W-1:0] ack_lvl_q;
    logic             sel_q;
    logic             to_slave_q;
    logic             end_first;
    logic             to_slave_now;
    logic             id_match;
    logic             selected_now;
    logic             do_set;

    // Decisions taken when the first pulse ends.
    always_comb begin
        end_first    = (state_q == ACK_FIRST) && inta_n;
        to_slave_now = is_master && win_valid && slave_map[win_lvl];
        id_match     = (cas_in == ident);
        selected_now = is_master ? !to_slave_now : id_match;
        do_set       = end_first && win_valid && (is_master || id_match);
        commit_set   = do_set ? (N'(1) << win_lvl) : '0;
    end

    // Pulse tracking and capture of the acknowledged line.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q    <= ACK_IDLE;
            ack_lvl_q  <= '0;
            sel_q      <= 1'b0;
            to_slave_q <= 1'b0;
        end else begin
            unique case (state_q)
                ACK_IDLE:   if (!inta_n) state_q <= ACK_FIRST;
                ACK_FIRST:  if (inta_n)  state_q <= ACK_GAP;
                ACK_GAP:    if (!inta_n) state_q <= ACK_SECOND;
                ACK_SECOND: if (inta_n)  state_q <= ACK_IDLE;
                default:                 state_q <= ACK_IDLE;
            endcase
            if (end_first) begin
                ack_lvl_q  <= win_valid ? win_lvl : '1;
                sel_q      <= selected_now;
                to_slave_q <= to_slave_now;
            end
        end
    end

    // Output gating for vector and cascade bus.
    always_comb begin
        vec_drive = (state_q == ACK_SECOND) && sel_q;
        ack_lvl   = ack_lvl_q;
        cas_out   = (state_q == ACK_FIRST) ? win_lvl : ack_lvl_q;
        cas_oe    = is_master &&
                    (((state_q == ACK_FIRST) && to_slave_now) ||
                     (((state_q == ACK_GAP) || (state_q == ACK_SECOND)) && to_slave_q));
    end

    a_r10_cas_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ACK_SECOND) |-> $stable(cas_out));
    a_r6_drive_after_low: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(vec_drive) |-> !$past(inta_n));
endmodule

// File: rtl/pic_regs.sv
// Register file: command decode, programmable registers and the in-service
// register with end-of-interrupt clearing. Assumes wr_fire is one cycle per
// write strobe and commit_set is one-hot or zero.
module pic_regs #(
    parameter int N      = pic_pkg::NUM_IRQ,
    parameter int LVL_W  = pic_pkg::LVL_W,
    parameter int DATA_W = pic_pkg::DATA_W,
    parameter int BASE_W = pic_pkg::BASE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_fire,
    input  logic              addr,
    input  logic [DATA_W-1:0] din,
    input  logic [N-1:0]      commit_set,
    output logic [N-1:0]      mask,
    output logic [N-1:0]      trig,
    output logic [N-1:0]      slave_map,
    output logic [BASE_W-1:0] base,
    output logic [LVL_W-1:0]  ident,
    output logic [N-1:0]      isr,
    output logic [2:0]        sel
);
    import pic_pkg::*;

    logic         wr_cmd;
    logic         wr_data;
    logic         is_eoi;
    logic [N-1:0] isr_low;
    logic [N-1:0] eoi_clr;
    logic [N-1:0] isr_next;

    // Decode writes and build the in-service update.
    always_comb begin
        wr_cmd   = wr_fire && !addr;
        wr_data  = wr_fire && addr;
        is_eoi   = wr_cmd && (din[7:6] == OP_EOI);
        isr_low  = isr & (~isr + N'(1));
        if (is_eoi) eoi_clr = din[5] ? (N'(1) << din[LVL_W-1:0]) : isr_low;
        else        eoi_clr = '0;
        isr_next = (isr & ~eoi_clr) | commit_set;
    end

    // Register state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mask      <= '1;
            trig      <= '0;
            slave_map <= '0;
            base      <= '0;
            ident     <= '0;
            isr       <= '0;
            sel       <= SEL_MASK;
        end else begin
            isr <= isr_next;
            if (wr_cmd && (din[7:6] == OP_SEL)) sel <= din[2:0];
            if (wr_data) begin
                case (sel)
                    SEL_MASK:   mask      <= din[N-1:0];
                    SEL_TRIG:   trig      <= din[N-1:0];
                    SEL_SLAVES: slave_map <= din[N-1:0];
                    SEL_BASE:   base      <= din[DATA_W-1:LVL_W];
                    SEL_IDENT:  ident     <= din[LVL_W-1:0];
                    default:    ;
                endcase
            end
        end
    end

    a_r8_eoi_no_growth: assert property (@(posedge clk) disable iff (!rst_n)
        (is_eoi && commit_set == '0) |=> ($countones(isr) <= $countones($past(isr))));
    a_r6_one_new_bit: assert property (@(posedge clk) disable iff (!rst_n)
        (|commit_set) |=> ($countones(isr & ~$past(isr)) == 1));
endmodule

// File: rtl/pic_cascade.sv
// Top of the cascadable priority interrupt controller. Samples the bus
// strobes on clk, ties capture, priority, registers and the acknowledge
// sequencer together, and muxes read data with the vector.
module pic_cascade #(
    parameter int N      = pic_pkg::NUM_IRQ,
    parameter int LVL_W  = pic_pkg::LVL_W,
    parameter int DATA_W = pic_pkg::DATA_W,
    parameter int BASE_W = pic_pkg::BASE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_n,
    input  logic              rd_n,
    input  logic              wr_n,
    input  logic              addr,
    input  logic [DATA_W-1:0] din,
    output logic [DATA_W-1:0] dout,
    output logic              dout_oe,
    input  logic [N-1:0]      irq,
    output logic              intr,
    input  logic              inta_n,
    input  logic              is_master,
    input  logic [LVL_W-1:0]  cas_in,
    output logic [LVL_W-1:0]  cas_out,
    output logic              cas_oe
);
    import pic_pkg::*;

    logic              bus_idle_q;
    logic              wr_fire;
    logic              rd_act;
    logic [N-1:0]      irr;
    logic [N-1:0]      mask;
    logic [N-1:0]      trig;
    logic [N-1:0]      slave_map;
    logic [BASE_W-1:0] base;
    logic [LVL_W-1:0]  ident;
    logic [N-1:0]      isr;
    logic [2:0]        sel;
    logic              win_valid;
    logic [LVL_W-1:0]  win_lvl;
    logic [N-1:0]      commit_set;
    logic              vec_drive;
    logic [LVL_W-1:0]  ack_lvl;
    logic [DATA_W-1:0] rd_data;

    // Remember whether the write strobe was inactive, for one write per strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) bus_idle_q <= 1'b1;
        else        bus_idle_q <= cs_n | wr_n;
    end

    assign wr_fire = !cs_n && !wr_n && bus_idle_q;
    assign rd_act  = !cs_n && !rd_n;

    pic_req_capture #(.N(N)) u_capture (
        .clk        (clk),
        .rst_n      (rst_n),
        .irq_async  (irq),
        .level_mode (trig),
        .ack_clr    (commit_set),
        .irr        (irr)
    );

    pic_priority #(.N(N), .LVL_W(LVL_W)) u_priority (
        .irr       (irr),
        .mask      (mask),
        .isr       (isr),
        .win_valid (win_valid),
        .win_lvl   (win_lvl)
    );

    pic_regs #(.N(N), .LVL_W(LVL_W), .DATA_W(DATA_W), .BASE_W(BASE_W)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_fire    (wr_fire),
        .addr       (addr),
        .din        (din),
        .commit_set (commit_set),
        .mask       (mask),
        .trig       (trig),
        .slave_map  (slave_map),
        .base       (base),
        .ident      (ident),
        .isr        (isr),
        .sel        (sel)
    );

    pic_ack_seq #(.N(N), .LVL_W(LVL_W)) u_ack (
        .clk        (clk),
        .rst_n      (rst_n),
        .inta_n     (inta_n),
        .is_master  (is_master),
        .win_valid  (win_valid),
        .win_lvl    (win_lvl),
        .slave_map  (slave_map),
        .cas_in     (cas_in),
        .ident      (ident),
        .commit_set (commit_set),
        .vec_drive  (vec_drive),
        .ack_lvl    (ack_lvl),
        .cas_out    (cas_out),
        .cas_oe     (cas_oe)
    );

    // Read mux for status and programmed registers.
    always_comb begin
        if (!addr) begin
            rd_data = DATA_W'(irr);
        end else begin
            case (sel)
                SEL_MASK:   rd_data = DATA_W'(mask);
                SEL_TRIG:   rd_data = DATA_W'(trig);
                SEL_SLAVES: rd_data = DATA_W'(slave_map);
                SEL_BASE:   rd_data = {base, {LVL_W{1'b0}}};
                SEL_IDENT:  rd_data = DATA_W'(ident);
                SEL_INSVC:  rd_data = DATA_W'(isr);
                default:    rd_data = '0;
            endcase
        end
    end

    // Output data: vector wins over a register read.
    always_comb begin
        dout    = vec_drive ? {base, ack_lvl} : rd_data;
        dout_oe = vec_drive | rd_act;
        intr    = win_valid;
    end

    a_r5_top_blocks_all: assert property (@(posedge clk) disable iff (!rst_n)
        isr[0] |-> !intr);
    a_r9_no_write_unselected: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n |=> $stable(mask));
endmodule

// File: tb/pic_cascade_tb.sv
`timescale 1ns/1ps
module pic_cascade_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cs_n = 1'b1, s_cs_n = 1'b1, rd_n = 1'b1, wr_n = 1'b1, addr = 1'b0;
    logic [7:0] din = '0;
    logic [7:0] m_irq = '0, s_irq = '0;
    logic       inta_n = 1'b1;
    logic [7:0] dout, s_dout, m_irq_w;
    logic       dout_oe, s_dout_oe, intr, s_intr, cas_oe, s_cas_oe;
    logic [2:0] cas_out, s_cas_out;
    int         n_tests = 0, n_fail = 0;
    bit         finished = 0;

    always #4 clk = ~clk;

    assign m_irq_w = m_irq | {5'b0, s_intr, 2'b0};

    pic_cascade u_dut (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .rd_n(rd_n), .wr_n(wr_n), .addr(addr),
        .din(din), .dout(dout), .dout_oe(dout_oe), .irq(m_irq_w), .intr(intr),
        .inta_n(inta_n), .is_master(1'b1), .cas_in(3'd0), .cas_out(cas_out), .cas_oe(cas_oe)
    );

    pic_cascade u_slave (
        .clk(clk), .rst_n(rst_n), .cs_n(s_cs_n), .rd_n(rd_n), .wr_n(wr_n), .addr(addr),
        .din(din), .dout(s_dout), .dout_oe(s_dout_oe), .irq(s_irq), .intr(s_intr),
        .inta_n(inta_n), .is_master(1'b0), .cas_in(cas_out), .cas_out(s_cas_out), .cas_oe(s_cas_oe)
    );

    // Stimulus table: {irq, mask, expected winning line}.
    localparam logic [23:0] PRIO_TBL [6] = '{
        {8'h81, 8'h00, 8'd0},
        {8'hF0, 8'h10, 8'd5},
        {8'h0C, 8'h00, 8'd2},
        {8'h80, 8'h00, 8'd7},
        {8'h06, 8'h02, 8'd2},
        {8'h41, 8'h01, 8'd6}
    };

    logic [7:0] v, sv, r;
    logic       oe, soe, coe;
    logic [2:0] cval;

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic a, input logic [7:0] d);
        @(negedge clk); cs_n = 0; wr_n = 0; addr = a; din = d;
        @(negedge clk); cs_n = 1; wr_n = 1;
    endtask

    task automatic wsl(input logic a, input logic [7:0] d);
        @(negedge clk); s_cs_n = 0; wr_n = 0; addr = a; din = d;
        @(negedge clk); s_cs_n = 1; wr_n = 1;
    endtask

    task automatic rd(input logic a, output logic [7:0] d);
        @(negedge clk); cs_n = 0; rd_n = 0; addr = a;
        #1 d = dout;
        cs_n = 1; rd_n = 1;
    endtask

    task automatic rsl(input logic a, output logic [7:0] d);
        @(negedge clk); s_cs_n = 0; rd_n = 0; addr = a;
        #1 d = s_dout;
        s_cs_n = 1; rd_n = 1;
    endtask

    task automatic ack(output logic [7:0] vo, output logic oeo, output logic coeo,
                       output logic [2:0] cvo, output logic [7:0] svo, output logic soeo);
        @(negedge clk); inta_n = 0;
        @(negedge clk);
        @(negedge clk); coeo = cas_oe; cvo = cas_out; inta_n = 1;
        @(negedge clk);
        @(negedge clk); inta_n = 0;
        @(negedge clk);
        @(negedge clk); vo = dout; oeo = dout_oe; svo = s_dout; soeo = s_dout_oe; inta_n = 1;
        @(negedge clk);
        @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        idle(4);
        rst_n = 1;
        idle(1);
        // Reset state.
        check("R3 reset intr", {7'b0, intr}, 8'h00);
        check("R6 reset dout_oe", {7'b0, dout_oe}, 8'h00);
        check("R10 reset cas_oe", {7'b0, cas_oe}, 8'h00);
        rd(1, r); check("R3 reset mask", r, 8'hFF);

        // R9: write without chip select is ignored.
        @(negedge clk); wr_n = 0; addr = 1; din = 8'h00;
        @(negedge clk); wr_n = 1;
        rd(1, r); check("R9 write without cs", r, 8'hFF);

        // Master base 0x40 -> vectors 0x40 + line.
        wr(0, 8'h43); wr(1, 8'h40);
        rd(1, r); check("R9 base readback", r, 8'h40);
        wr(0, 8'h40);

        // R4: priority table walk.
        foreach (PRIO_TBL[i]) begin
            wr(1, PRIO_TBL[i][15:8]);
            m_irq = PRIO_TBL[i][23:16];
            idle(5);
            check($sformatf("R5 intr entry %0d", i), {7'b0, intr}, 8'h01);
            ack(v, oe, coe, cval, sv, soe);
            check($sformatf("R4 vector entry %0d", i), v, 8'h40 | PRIO_TBL[i][7:0]);
            check($sformatf("R6 oe entry %0d", i), {7'b0, oe}, 8'h01);
            wr(0, 8'h00);
            m_irq = 8'h00;
            idle(4);
        end
        wr(1, 8'h00);

        // R1: edge capture, no re-request while held, drop before acknowledge.
        m_irq = 8'h08; idle(5);
        rd(0, r); check("R1 edge pending", r, 8'h08);
        ack(v, oe, coe, cval, sv, soe);
        check("R1 edge vector", v, 8'h43);
        check("R10 no cascade for unmapped line", {7'b0, coe}, 8'h00);
        idle(3); rd(0, r); check("R1 held high no re-request", r, 8'h00);
        wr(0, 8'h00); idle(3);
        check("R1 intr after eoi held high", {7'b0, intr}, 8'h00);
        m_irq = 8'h00; idle(3);
        m_irq = 8'h10; idle(5); m_irq = 8'h00; idle(4);
        rd(0, r); check("R1 dropped before ack", r, 8'h00);

        // R2: level capture on line 4.
        wr(0, 8'h41); wr(1, 8'h10);
        m_irq = 8'h10; idle(5);
        ack(v, oe, coe, cval, sv, soe);
        check("R2 level vector", v, 8'h44);
        wr(0, 8'h00); idle(3);
        rd(0, r); check("R2 level re-pending", r, 8'h10);
        check("R2 level intr again", {7'b0, intr}, 8'h01);
        m_irq = 8'h00; idle(4);
        rd(0, r); check("R2 level released", r, 8'h00);
        wr(1, 8'h00); wr(0, 8'h40);

        // R3: masking hides intr but not the pending bit.
        wr(1, 8'h40);
        m_irq = 8'h40; idle(5);
        check("R3 masked intr", {7'b0, intr}, 8'h00);
        rd(0, r); check("R3 masked still pending", r, 8'h40);
        wr(1, 8'h00);
        check("R3 unmasked intr", {7'b0, intr}, 8'h01);
        ack(v, oe, coe, cval, sv, soe);
        check("R3 vector after unmask", v, 8'h46);
        wr(0, 8'h00); m_irq = 8'h00; idle(4);

        // R5 nesting and R8 end-of-interrupt forms.
        m_irq = 8'h20; idle(5);
        ack(v, oe, coe, cval, sv, soe);
        check("R4 nest first vector", v, 8'h45);
        m_irq = 8'h60; idle(5);
        check("R5 lower blocked", {7'b0, intr}, 8'h00);
        m_irq = 8'h40; idle(3); m_irq = 8'h60; idle(5);
        check("R5 equal blocked", {7'b0, intr}, 8'h00);
        m_irq = 8'h62; idle(5);
        check("R5 higher passes", {7'b0, intr}, 8'h01);
        ack(v, oe, coe, cval, sv, soe);
        check("R5 nested vector", v, 8'h41);
        wr(0, 8'h45);
        rd(1, r); check("R6 isr nested", r, 8'h22);
        wr(0, 8'h00);
        rd(1, r); check("R8 nonspecific eoi", r, 8'h20);
        wr(0, 8'h25);
        rd(1, r); check("R8 specific eoi", r, 8'h00);
        check("R5 pending after eoi", {7'b0, intr}, 8'h01);
        ack(v, oe, coe, cval, sv, soe); check("R4 line 5 next", v, 8'h45);
        wr(0, 8'h00);
        ack(v, oe, coe, cval, sv, soe); check("R4 line 6 last", v, 8'h46);
        wr(0, 8'h00);
        m_irq = 8'h00; idle(4);

        // R7: spurious acknowledge.
        ack(v, oe, coe, cval, sv, soe);
        check("R7 spurious vector", v, 8'h47);
        check("R7 spurious oe", {7'b0, oe}, 8'h01);
        rd(1, r); check("R7 isr unchanged", r, 8'h00);

        // Same-cycle commit and end-of-interrupt (R6, R8).
        m_irq = 8'h08; idle(5);
        ack(v, oe, coe, cval, sv, soe); check("R6 line 3 vector", v, 8'h43);
        m_irq = 8'h0A; idle(5);
        @(negedge clk); inta_n = 0;
        @(negedge clk);
        @(negedge clk); inta_n = 1; cs_n = 0; wr_n = 0; addr = 0; din = 8'h00;
        @(negedge clk); cs_n = 1; wr_n = 1;
        @(negedge clk); inta_n = 0;
        @(negedge clk);
        @(negedge clk); v = dout; inta_n = 1;
        idle(2);
        check("R6 vector with concurrent eoi", v, 8'h41);
        rd(1, r); check("R8 eoi and commit same cycle", r, 8'h02);
        wr(0, 8'h00); m_irq = 8'h00; idle(4);

        // Cascade: master line 2 carries the subordinate.
        wr(0, 8'h42); wr(1, 8'h04);
        wsl(0, 8'h40); wsl(1, 8'h00);
        wsl(0, 8'h43); wsl(1, 8'h80);
        wsl(0, 8'h44); wsl(1, 8'h02);
        s_irq = 8'h20; idle(8);
        check("R10 master intr from subordinate", {7'b0, intr}, 8'h01);
        ack(v, oe, coe, cval, sv, soe);
        check("R10 cas_oe", {7'b0, coe}, 8'h01);
        check("R10 cas value", {5'b0, cval}, 8'h02);
        check("R10 master silent", {7'b0, oe}, 8'h00);
        check("R11 subordinate oe", {7'b0, soe}, 8'h01);
        check("R11 subordinate vector", sv, 8'h85);
        wsl(0, 8'h45); rsl(1, r); check("R11 subordinate isr", r, 8'h20);
        wsl(0, 8'h00); wr(0, 8'h00);
        s_irq = 8'h00; idle(8);

        // R11: identity mismatch.
        wsl(0, 8'h44); wsl(1, 8'h03);
        s_irq = 8'h08; idle(8);
        ack(v, oe, coe, cval, sv, soe);
        check("R11 mismatch no oe", {7'b0, soe}, 8'h00);
        check("R10 master still silent", {7'b0, oe}, 8'h00);
        wsl(0, 8'h45); rsl(1, r); check("R11 mismatch isr", r, 8'h00);

        finished = 1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule